// File: doc/BRIEF.md
# Multiplexed Address/Data Burst PSRAM Controller

This block sits on the host side of a pseudo-static RAM that shares one 16-bit bus between address and data. It takes one burst request at a time from a local valid/ready port: a start word address, a word count and a byte enable pair. It then runs the memory bus from the same clock. For each burst it drives a one-cycle address phase, counts the fixed initial latency and moves data words. WAIT from the memory marks the cycles in which no word moves. The memory is assumed to be set up for continuous sequential bursts. The controller keeps its own word pointer, so a request of any length maps onto one or more bus bursts.

The device refreshes its array on its own, but only while chip enable is high. The controller therefore caps every chip-enable-low window with a cycle counter. A long request is cut into several bursts, and each new burst restarts at the next untransferred address. A write that meets WAIT in mid-transfer is closed at once. It is reopened later at the same address with the same held word. A read that meets WAIT keeps its pointer and carries on when WAIT drops. If the write stream runs dry in mid-burst, the write burst is also closed and resumed later.

Back-pressure: a request is taken on a cycle where `req_valid` and `req_ready` are both high. A write word is taken on a cycle where `wdata_valid` and `wdata_ready` are both high. Once `wdata_valid` is raised it must stay high, with `wdata` unchanged, until that word is taken. Read words come out as single-cycle `rdata_valid` pulses with no ready signal, because the memory burst cannot be stalled from the host side.

Top module: `admux_burst_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` and `rdata_valid` are low and `req_ready` is high. `req_ready` is high only while no request is in progress and chip enable is high.
- R2: Each burst opens with `mem_adv_n` low for exactly one cycle, with `mem_ce_n` low. In that cycle the bus carries word address bits 15:0 on `mem_dq_o` and the upper bits on `mem_a_hi`. The address is the first word of the request not yet transferred. `mem_we_n` is low from that cycle on for writes.
- R3: The first word of a burst moves on the LATENCY-th rising edge after the edge that sampled the address phase. On reads the controller stops driving the bus (`mem_dq_oe` low) and holds `mem_oe_n` low during the latency and data cycles.
- R4: Read words come back in address order. Each word is sampled from `mem_dq_i` on its transfer edge and shown on `rdata` with a one-cycle `rdata_valid` pulse in the cycle that follows. `rdata_last` is high with the final word of the request.
- R5: WAIT is sampled on the rising edge, and its active level is set by WAIT_ACTIVE_LOW (default: active low). During a read data phase, an edge that samples WAIT active moves no word and does not advance the address. Transfer resumes on the first edge with WAIT inactive.
- R6: If WAIT is sampled active during a write data phase, `mem_ce_n` is high by the next rising edge. The word not taken is written by a later burst at its own address.
- R7: On the edge where the final word of a request moves, the controller raises `mem_ce_n`, so it is high at the next rising edge.
- R8: `mem_ce_n` is never low for more than CEM_CYCLES consecutive rising edges. A longer request is split into several bursts with no word lost or repeated.
- R9: Between two bursts `mem_ce_n` stays high for at least GAP_CYCLES rising edges.
- R10: Write words are taken only through the valid/ready handshake, in order, one per word. `mem_lb_n` is the inverse of byte-enable bit 0 (bits 7:0) and `mem_ub_n` the inverse of bit 1 (bits 15:8). If no word is offered when the next one is due, the burst closes and later resumes with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Word count minus one |
| req_be | input | 2 | Byte enables for writes (bit 0 low byte, bit 1 high byte) |
| wdata_valid | input | 1 | Write word offered |
| wdata_ready | output | 1 | Write word taken this cycle |
| wdata | input | 16 | Write word |
| rdata_valid | output | 1 | Read word present (no back-pressure) |
| rdata | output | 16 | Read word |
| rdata_last | output | 1 | Final word of the read request |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_a_hi | output | AW-16 | Upper word address bits |
| mem_dq_o | output | 16 | Shared bus, driven value |
| mem_dq_oe | output | 1 | Shared bus drive enable |
| mem_dq_i | input | 16 | Shared bus, received value |
| mem_wait | input | 1 | Memory WAIT |

## Verification
The bound checker checks several rules on every cycle:
- the one-cycle address strobe and its pairing with chip enable;
- the bus never being driven while output enable is low;
- a read response following a read cycle;
- chip enable rising after a final word or a write WAIT;
- the maximum low window and the minimum high gap of chip enable, both measured with counters.

Other behaviours need the bench's memory model, which inserts row-crossing WAIT cycles and compares every clock against its own expected read stream:
- the data values themselves;
- the restart address after each split;
- the effect of byte enables;
- the absence of lost or repeated words when a write is interrupted by WAIT or by a gap in the write stream.

// File: rtl/admux_pkg.sv
package admux_pkg;
  localparam int DQ_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LAT,
    ST_XFER
  } bus_st_t;
endpackage

// File: rtl/admux_ce_guard.sv
// Tracks how long chip enable has been low and how long it has been high.
module admux_ce_guard #(
  parameter int CEM_CYCLES = 64,
  parameter int GAP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic must_close,
  output logic gap_ok
);
  localparam int CW = $clog2(CEM_CYCLES + 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic [CW-1:0] low_cnt;
  logic [GW-1:0] high_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else begin
      if (ce_n) low_cnt <= '0;
      else if (low_cnt < CW'(CEM_CYCLES)) low_cnt <= low_cnt + 1'b1;
      if (!ce_n) high_cnt <= '0;
      else if (high_cnt < GW'(GAP_CYCLES)) high_cnt <= high_cnt + 1'b1;
    end
  end

  // The current edge is the last low edge the window allows.
  assign must_close = !ce_n && (low_cnt >= CW'(CEM_CYCLES - 1));
  // The current edge completes the minimum high time.
  assign gap_ok     = ce_n && (high_cnt >= GW'(GAP_CYCLES - 1));
endmodule

// File: rtl/admux_job_track.sv
// Holds the request in progress: next word address and words remaining.
module admux_job_track #(
  parameter int AW = 23,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_write,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_len,
  input  logic [1:0]    load_be,
  input  logic          step,
  output logic          busy,
  output logic          last,
  output logic          is_write,
  output logic [AW-1:0] addr,
  output logic [1:0]    be
);
  localparam int RW = LW + 1;

  logic [RW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain   <= '0;
      addr     <= '0;
      is_write <= 1'b0;
      be       <= 2'b00;
    end else if (load) begin
      remain   <= RW'(load_len) + 1'b1;
      addr     <= load_addr;
      is_write <= load_write;
      be       <= load_be;
    end else if (step && remain != '0) begin
      remain <= remain - 1'b1;
      addr   <= addr + 1'b1;
    end
  end

  assign busy = (remain != '0);
  assign last = (remain == RW'(1));
endmodule

// File: rtl/admux_burst_ctrl.sv
module admux_burst_ctrl
  import admux_pkg::*;
#(
  parameter int AW              = 23,
  parameter int LW              = 8,
  parameter int LATENCY         = 3,
  parameter int CEM_CYCLES      = 64,
  parameter int GAP_CYCLES      = 1,
  parameter bit WAIT_ACTIVE_LOW = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [LW-1:0]    req_len,
  input  logic [1:0]       req_be,
  input  logic             wdata_valid,
  output logic             wdata_ready,
  input  logic [DQ_W-1:0]  wdata,
  output logic             rdata_valid,
  output logic [DQ_W-1:0]  rdata,
  output logic             rdata_last,
  output logic             mem_ce_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_lb_n,
  output logic             mem_ub_n,
  output logic [AW-17:0]   mem_a_hi,
  output logic [DQ_W-1:0]  mem_dq_o,
  output logic             mem_dq_oe,
  input  logic [DQ_W-1:0]  mem_dq_i,
  input  logic             mem_wait
);
  localparam int LATW = (LATENCY > 2) ? $clog2(LATENCY) : 1;

  initial begin
    if (LATENCY < 2) $error("LATENCY must be at least 2");
    if (CEM_CYCLES < LATENCY + 2) $error("CEM_CYCLES too small for LATENCY");
    if (AW <= DQ_W) $error("AW must exceed the bus width");
  end

  bus_st_t         st;
  logic [LATW-1:0] lat_cnt;
  logic [DQ_W-1:0] hold_word;
  logic            hold_vld;

  logic busy, last, is_write;
  logic [AW-1:0] addr;
  logic [1:0]    be;
  logic must_close, gap_ok;

  logic wait_act, accept, open_ok, xfer_ok, lat_done;
  logic pop_first, pop_next, xfer_close;

  admux_job_track #(.AW(AW), .LW(LW)) u_job (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_write(req_write), .load_addr(req_addr),
    .load_len(req_len), .load_be(req_be),
    .step(xfer_ok),
    .busy(busy), .last(last), .is_write(is_write), .addr(addr), .be(be)
  );

  admux_ce_guard #(.CEM_CYCLES(CEM_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n),
    .must_close(must_close), .gap_ok(gap_ok)
  );

  // Handshake and transfer decisions for the coming edge.
  always_comb begin
    wait_act   = WAIT_ACTIVE_LOW ? ~mem_wait : mem_wait;
    req_ready  = (st == ST_IDLE) && !busy;
    accept     = req_valid && req_ready;
    open_ok    = (st == ST_IDLE) && busy && gap_ok &&
                 (!is_write || hold_vld || wdata_valid);
    xfer_ok    = (st == ST_XFER) && !wait_act;
    lat_done   = (st == ST_LAT) && !must_close && (lat_cnt == '0);
    pop_first  = lat_done && is_write && !hold_vld;
    pop_next   = xfer_ok && is_write && !last && !must_close && wdata_valid;
    wdata_ready = pop_first || pop_next;
    // Writes close unless the next word is loaded; reads close at the end or at the window limit.
    if (is_write) xfer_close = !pop_next;
    else          xfer_close = must_close || (xfer_ok && last);
  end

  // Bus pins follow the registered state.
  always_comb begin
    mem_ce_n  = (st == ST_IDLE);
    mem_adv_n = (st != ST_ADDR);
    mem_we_n  = !(is_write && st != ST_IDLE);
    mem_oe_n  = !(!is_write && (st == ST_LAT || st == ST_XFER));
    mem_dq_oe = (st == ST_ADDR) || (is_write && (st == ST_LAT || st == ST_XFER));
    mem_dq_o  = (st == ST_ADDR) ? addr[DQ_W-1:0] : hold_word;
    mem_a_hi  = addr[AW-1:DQ_W];
    mem_lb_n  = (st == ST_IDLE) || (is_write && !be[0]);
    mem_ub_n  = (st == ST_IDLE) || (is_write && !be[1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lat_cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (open_ok) st <= ST_ADDR;
        ST_ADDR: begin
          st      <= ST_LAT;
          lat_cnt <= LATW'(LATENCY - 2);
        end
        ST_LAT: begin
          if (must_close)          st <= ST_IDLE;
          else if (lat_cnt == '0)  st <= ST_XFER;
          else                     lat_cnt <= lat_cnt - 1'b1;
        end
        ST_XFER: if (xfer_close) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Write word holding: a taken word stays until the memory accepts it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_vld  <= 1'b0;
    end else if (wdata_ready) begin
      hold_word <= wdata;
      hold_vld  <= 1'b1;
    end else if (xfer_ok && is_write) begin
      hold_vld  <= 1'b0;
    end
  end

  // Read return path.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_valid <= 1'b0;
      rdata       <= '0;
      rdata_last  <= 1'b0;
    end else begin
      rdata_valid <= xfer_ok && !is_write;
      if (xfer_ok && !is_write) begin
        rdata      <= mem_dq_i;
        rdata_last <= last;
      end
    end
  end
endmodule

// File: rtl/admux_burst_ctrl_chk.sv
module admux_burst_ctrl_chk
  import admux_pkg::*;
#(
  parameter int CEM_CYCLES = 64,
  parameter int GAP_CYCLES = 1
) (
  input logic    clk,
  input logic    rst_n,
  input logic    mem_ce_n,
  input logic    mem_adv_n,
  input logic    mem_oe_n,
  input logic    mem_dq_oe,
  input logic    req_ready,
  input logic    rdata_valid,
  input logic    mem_we_n,
  input logic    wait_act,
  input logic    is_write,
  input logic    last,
  input bus_st_t st
);
  logic [31:0] low_run, high_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= mem_ce_n ? '0 : low_run + 1;
      high_run <= mem_ce_n ? ((high_run < 32'd1000) ? high_run + 1 : high_run) : '0;
    end
  end

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);
  assert_adv_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);
  assert_adv_with_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_ce_n);
  assert_no_contention_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(!mem_ce_n && mem_we_n));
  assert_wr_wait_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER && is_write && wait_act) |=> mem_ce_n);
  assert_last_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER && last && !wait_act) |=> mem_ce_n);
  assert_ce_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (low_run < CEM_CYCLES));
  assert_ce_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (high_run >= GAP_CYCLES));
endmodule

bind admux_burst_ctrl admux_burst_ctrl_chk #(
  .CEM_CYCLES(CEM_CYCLES), .GAP_CYCLES(GAP_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .req_ready(req_ready),
  .rdata_valid(rdata_valid), .mem_we_n(mem_we_n), .wait_act(wait_act),
  .is_write(is_write), .last(last), .st(st)
);

// File: tb/admux_burst_ctrl_test.sv
`timescale 1ns/1ps
module admux_burst_ctrl_test;
  localparam int AW = 23, LW = 8, LAT = 3, CEM = 20, GAP = 1;
  localparam int ROW = 16, STALL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [1:0] req_be = 2'b11;
  logic wdata_valid = 0;
  logic [15:0] wdata = '0;
  logic req_ready, wdata_ready, rdata_valid, rdata_last;
  logic [15:0] rdata, mem_dq_o;
  logic mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [AW-17:0] mem_a_hi;
  logic [15:0] mem_dq_i = 16'hDEAD;
  logic mem_wait = 1'b1;

  always #2.5 clk = ~clk;

  admux_burst_ctrl #(.AW(AW), .LW(LW), .LATENCY(LAT), .CEM_CYCLES(CEM),
                     .GAP_CYCLES(GAP), .WAIT_ACTIVE_LOW(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .rdata_valid(rdata_valid), .rdata(rdata), .rdata_last(rdata_last),
    .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_a_hi(mem_a_hi), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_wait(mem_wait));

  int n_checks = 0, n_fail = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model state.
  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  int lat_left = 0, stall_left = 0, ptr = 0;
  bit in_burst = 0, bwrite = 0;
  int rd_left = 0, wr_left = 0, exp_next = 0, n_bursts = 0;
  logic exp_rv = 0, exp_rlast = 0, exp_fin = 0;
  logic [15:0] exp_rd = '0;

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 16'h1000 + 16'(i * 5);
    ref_mem[i] = 16'h1000 + 16'(i * 5);
  end

  always @(posedge clk) begin
    exp_rv  <= 1'b0;
    exp_fin <= 1'b0;
    if (!rst_n || mem_ce_n) begin
      in_burst = 0;
      mem_wait <= 1'b1;
      mem_dq_i <= 16'hDEAD;
    end else begin
      if (!mem_adv_n) begin
        in_burst = 1; bwrite = !mem_we_n;
        ptr = int'(mem_dq_o[7:0]); lat_left = LAT - 1; stall_left = 0;
        n_bursts++;
        chk({mem_a_hi, mem_dq_o} == 23'(exp_next), "R2 burst address", 32'({mem_a_hi, mem_dq_o}), 32'(exp_next));
      end else if (in_burst) begin
        if (lat_left > 0) lat_left--;
        else if (stall_left > 0) stall_left--;
        else begin
          if (bwrite) begin
            if (!mem_lb_n) mem[ptr][7:0] = mem_dq_o[7:0];
            if (!mem_ub_n) mem[ptr][15:8] = mem_dq_o[15:8];
            wr_left--;
            if (wr_left == 0) exp_fin <= 1'b1;
          end else begin
            chk(!mem_oe_n && !mem_dq_oe, "R3 read bus released", {30'd0, mem_oe_n, mem_dq_oe}, 32'd0);
            exp_rv <= 1'b1; exp_rd <= ref_mem[ptr]; exp_rlast <= (rd_left == 1);
            rd_left--;
            if (rd_left == 0) exp_fin <= 1'b1;
          end
          exp_next++;
          ptr = (ptr + 1) % 256;
          if (ptr % ROW == 0) stall_left = STALL;
        end
      end
      mem_wait <= (lat_left > 0 || stall_left > 0) ? 1'b0 : 1'b1;
      mem_dq_i <= (lat_left == 0 && stall_left == 0) ? mem[ptr] : 16'hDEAD;
    end
  end

  // Per-clock comparison against the model's expectations.
  int low_run = 0, max_low = 0;
  always @(negedge clk) if (rst_n) begin
    chk(rdata_valid == exp_rv, "R4 rdata_valid timing", 32'(rdata_valid), 32'(exp_rv));
    if (exp_rv) begin
      chk(rdata == exp_rd, "R4 read data", 32'(rdata), 32'(exp_rd));
      chk(rdata_last == exp_rlast, "R4 rdata_last", 32'(rdata_last), 32'(exp_rlast));
    end
    if (exp_fin) chk(mem_ce_n == 1'b1, "R7 CE high after last word", 32'(mem_ce_n), 32'd1);
    low_run = mem_ce_n ? 0 : low_run + 1;
    if (low_run > max_low) max_low = low_run;
  end

  // Write data stream source.
  logic [15:0] wq [$];
  bit gap_mode = 0;
  int gap_left = 0;
  always @(posedge clk) begin
    bit popped;
    popped = wdata_valid && wdata_ready;
    if (popped) begin
      void'(wq.pop_front());
      gap_left = gap_mode ? 3 : 0;
    end
    if (wdata_valid && !popped) begin
    end else if (gap_left > 0) begin
      gap_left--;
      wdata_valid <= 1'b0;
    end else if (wq.size() > 0) begin
      wdata_valid <= 1'b1;
      wdata <= wq[0];
    end else wdata_valid <= 1'b0;
  end

  task automatic wait_done(input string tag);
    int t = 0;
    do begin @(negedge clk); t++; end
    while (!(req_ready && rd_left == 0 && wr_left == 0 && wq.size() == 0) && t < 3000);
    chk(t < 3000, tag, 32'(t), 32'd3000);
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input int a, input int n, input logic [1:0] be);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", 32'(req_ready), 32'd1);
    exp_next = a;
    if (wr) wr_left = n; else rd_left = n;
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_len = LW'(n - 1); req_be = be;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input int a, input int n, input logic [1:0] be, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [15:0] v;
      v = 16'hA000 + 16'((a + i) * 7 + seed);
      wq.push_back(v);
      if (be[0]) ref_mem[(a + i) % 256][7:0] = v[7:0];
      if (be[1]) ref_mem[(a + i) % 256][15:8] = v[15:8];
    end
    issue(1, a, n, be);
    wait_done("R10 write completes");
  endtask

  task automatic do_read(input int a, input int n);
    issue(0, a, n, 2'b11);
    wait_done("R4 read completes");
  endtask

  task automatic cmp_mem(input int a, input int n, input string tag);
    for (int i = 0; i < n; i++)
      chk(mem[(a + i) % 256] == ref_mem[(a + i) % 256], tag,
          32'(mem[(a + i) % 256]), 32'(ref_mem[(a + i) % 256]));
  endtask

  initial begin
    int b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n, "R1 reset strobes high",
        {28'd0, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n}, 32'hF);
    chk(!mem_dq_oe && !rdata_valid && req_ready, "R1 reset bus and ready",
        {29'd0, mem_dq_oe, rdata_valid, req_ready}, 32'd1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    do_write(16, 8, 2'b11, 1);           // R10 plain write within a row
    cmp_mem(16, 8, "R10 full-word write");
    do_read(16, 8);                      // R3 R4 read back

    b0 = n_bursts;
    do_write(28, 6, 2'b11, 2);           // R6 write crosses a row
    cmp_mem(28, 6, "R6 write across row");
    chk(n_bursts - b0 >= 2, "R6 write reopened", 32'(n_bursts - b0), 32'd2);

    do_read(26, 10);                     // R5 read stalls at row crossing

    do_write(64, 4, 2'b01, 3);           // R10 low byte only
    do_write(68, 4, 2'b10, 4);           // R10 high byte only
    cmp_mem(64, 8, "R10 byte enables");

    b0 = n_bursts;
    do_read(80, 60);                     // R8 long read split
    chk(n_bursts - b0 >= 3, "R8 long read split", 32'(n_bursts - b0), 32'd3);
    chk(max_low <= CEM, "R8 CE low window", 32'(max_low), 32'(CEM));

    b0 = n_bursts;
    gap_mode = 1;
    do_write(128, 10, 2'b11, 5);         // R10 stream gaps close the burst
    gap_mode = 0;
    cmp_mem(128, 10, "R10 gapped write");
    chk(n_bursts - b0 >= 2, "R10 gap resumes", 32'(n_bursts - b0), 32'd2);
    chk(max_low <= CEM, "R9 R8 window after writes", 32'(max_low), 32'(CEM));

    do_read(129, 1);                     // R7 single word, last on first

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule